// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block keeps a small ring of receive descriptors in on-chip storage and hands them to software one frame at a time. Each descriptor holds four status flags, a byte count and a buffer address. A finished frame is presented as a length and an error bit on a one-cycle strobe. The engine fills the descriptor under its ring index, passes ownership to the host, and moves to the next entry. The move follows the descriptor's own wrap flag, so software can shorten the ring.

Software returns descriptors through a host port. A return re-arms the entry, and it also restarts reception if the engine had stopped. Reception stops when a frame arrives and the current descriptor still belongs to the host. The frame is then dropped and a sticky overrun flag is raised. A registered read port lets software inspect any descriptor. The buffer address field is only written and read by the host. Moving payload bytes into memory is not part of this block.

Top module: `rxdesc_ring`

## Requirements
- R1: After reset, every descriptor has EMPTY=1, LAST=0 and ERR=0. Only the highest index has WRAP=1. `cur_idx` is 0, `rx_active` is 1, and `overrun` and `frame_done` are 0.
- R2: `rd_status` packs the flags as bit0 EMPTY, bit1 WRAP, bit2 LAST, bit3 ERR. `host_ptr_we` stores `host_ptr_data` as the buffer address of `host_ptr_idx`, and `rd_ptr` returns it.
- R3: A frame strobe that finds the engine active and the current descriptor EMPTY fills that descriptor. EMPTY is cleared, LAST is set, WRAP is kept and the length becomes `frm_len`. In the cycle after the strobe, `frame_done` is high for exactly one cycle and `done_idx` names the filled index.
- R4: After a fill, the ring index becomes 0 if the filled descriptor had WRAP=1. Otherwise it steps by one, and it goes back to 0 past the highest index. The index changes only on a fill.
- R5: ERR is written as 1 when `frm_err` is 1, when `frm_len` is above 1518, or when `frm_len` is 14 or less. Otherwise ERR is written as 0. Bad frames are still handed over so that software can recycle them.
- R6: A frame strobe that finds the current descriptor not EMPTY writes nothing. It sets `overrun`, which stays set until reset, and it drops `rx_active` to 0.
- R7: While `rx_active` is 0, frame strobes are dropped. No descriptor, length or index changes, and `overrun` is set.
- R8: `host_ret` on index i sets EMPTY, clears LAST and ERR and zeroes the length. It sets WRAP to `host_ret_wrap`, or to 1 when i is the highest index.
- R9: `host_ret` sets `rx_active` to 1 at the next edge. This holds even if a frame strobe in the same cycle would stop the engine.
- R10: A frame strobe and a host return in the same cycle are both applied. The frame is judged on the descriptor state before that edge. If both target one index, the fill overrides the return. `rd_status`, `rd_len` and `rd_ptr` show the state of `host_rd_idx` from before the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: a frame has finished |
| frm_len | input | LEN_W | Received byte count |
| frm_err | input | 1 | Frame received with an error |
| host_ret | input | 1 | Return a descriptor to the engine |
| host_ret_idx | input | IDX_W | Index being returned |
| host_ret_wrap | input | 1 | Make the returned entry close the ring |
| host_ptr_we | input | 1 | Write a buffer address |
| host_ptr_idx | input | IDX_W | Index for the address write |
| host_ptr_data | input | PTR_W | Buffer address |
| host_rd_idx | input | IDX_W | Index to read back |
| rd_status | output | 4 | Flags of the read index |
| rd_len | output | LEN_W | Length of the read index |
| rd_ptr | output | PTR_W | Buffer address of the read index |
| frame_done | output | 1 | One-cycle pulse per descriptor handed over |
| done_idx | output | IDX_W | Index handed over |
| cur_idx | output | IDX_W | Current ring index |
| rx_active | output | 1 | Reception running |
| overrun | output | 1 | Sticky frame-dropped flag |

## Verification
The hard case is a frame strobe and a host return landing on the same clock edge. This includes a stalled engine whose blocking descriptor is returned in the very cycle a new frame arrives. That frame must still be dropped, the overrun must be recorded, and reception must come out running. The bench provokes this with directed collisions on the same index and on different indices. Random cycles then mix both operations freely. A bench model updates from the pre-edge state with the fill applied after the return. Every descriptor is read back through the host port and compared against that model.

// File: rtl/rxdesc_pkg.sv
package rxdesc_pkg;

  // packed so that bit0 = empty, bit1 = wrap, bit2 = last, bit3 = err
  typedef struct packed {
    logic err;
    logic last;
    logic wrap;
    logic empty;
  } desc_flags_t;

  function automatic desc_flags_t armed_flags(input logic wrap_bit);
    desc_flags_t f;
    f.err   = 1'b0;
    f.last  = 1'b0;
    f.wrap  = wrap_bit;
    f.empty = 1'b1;
    return f;
  endfunction

endpackage

// File: rtl/rxdesc_ram.sv
module rxdesc_ram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_a,
  input  logic [AW-1:0]    addr_a,
  input  logic [WIDTH-1:0] din_a,
  input  logic             we_b,
  input  logic [AW-1:0]    addr_b,
  input  logic [WIDTH-1:0] din_b,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] mem [DEPTH];

  // port b is written last, so it wins on an address clash
  always_ff @(posedge clk) begin
    if (we_a) mem[addr_a] <= din_a;
    if (we_b) mem[addr_b] <= din_b;
    dout <= mem[raddr];
  end

endmodule

// File: rtl/rxdesc_ctrl.sv
module rxdesc_ctrl
  import rxdesc_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int LEN_W    = 16,
  parameter int MAX_LEN  = 1518,
  parameter int RUNT_MAX = 14,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             frm_err,
  input  logic             host_ret,
  input  logic [IDX_W-1:0] host_ret_idx,
  input  logic             host_ret_wrap,
  input  logic [IDX_W-1:0] host_rd_idx,
  output logic             fill_we,
  output logic [IDX_W-1:0] fill_idx,
  output desc_flags_t      rd_flags,
  output logic             frame_done,
  output logic [IDX_W-1:0] done_idx,
  output logic [IDX_W-1:0] cur_idx,
  output logic             rx_active,
  output logic             overrun
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

  desc_flags_t      flags [NUM_DESC];
  desc_flags_t      cur_flags;
  logic [IDX_W-1:0] cur_q;
  logic [IDX_W-1:0] next_idx;
  logic             accept;
  logic             drop;
  logic             bad;

  assign cur_flags = flags[cur_q];
  assign accept    = frm_valid && rx_active && cur_flags.empty;
  assign drop      = frm_valid && !accept;
  assign bad       = frm_err || (frm_len > LEN_W'(MAX_LEN)) ||
                     (frm_len <= LEN_W'(RUNT_MAX));

  always_comb begin
    if (cur_flags.wrap || cur_q == LAST_IDX) next_idx = '0;
    else                                     next_idx = cur_q + 1'b1;
  end

  assign fill_we  = accept;
  assign fill_idx = cur_q;
  assign cur_idx  = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_DESC; i++)
        flags[i] <= armed_flags(i == NUM_DESC - 1);
      cur_q      <= '0;
      rx_active  <= 1'b1;
      overrun    <= 1'b0;
      frame_done <= 1'b0;
      done_idx   <= '0;
      rd_flags   <= '0;
    end else begin
      frame_done <= accept;
      rd_flags   <= flags[host_rd_idx];
      if (drop) begin
        overrun   <= 1'b1;
        rx_active <= 1'b0;
      end
      if (host_ret) begin
        rx_active           <= 1'b1;
        flags[host_ret_idx] <= armed_flags(host_ret_wrap || host_ret_idx == LAST_IDX);
      end
      if (accept) begin
        flags[cur_q] <= '{err: bad, last: 1'b1, wrap: cur_flags.wrap, empty: 1'b0};
        done_idx     <= cur_q;
        cur_q        <= next_idx;
      end
    end
  end

endmodule

// File: rtl/rxdesc_ring.sv
module rxdesc_ring
  import rxdesc_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int LEN_W    = 16,
  parameter int PTR_W    = 32,
  parameter int MAX_LEN  = 1518,
  parameter int RUNT_MAX = 14,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             frm_err,
  input  logic             host_ret,
  input  logic [IDX_W-1:0] host_ret_idx,
  input  logic             host_ret_wrap,
  input  logic             host_ptr_we,
  input  logic [IDX_W-1:0] host_ptr_idx,
  input  logic [PTR_W-1:0] host_ptr_data,
  input  logic [IDX_W-1:0] host_rd_idx,
  output logic [3:0]       rd_status,
  output logic [LEN_W-1:0] rd_len,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             frame_done,
  output logic [IDX_W-1:0] done_idx,
  output logic [IDX_W-1:0] cur_idx,
  output logic             rx_active,
  output logic             overrun
);

  logic             fill_we;
  logic [IDX_W-1:0] fill_idx;
  desc_flags_t      rd_flags;

  rxdesc_ctrl #(
    .NUM_DESC(NUM_DESC), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .RUNT_MAX(RUNT_MAX)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .frm_valid(frm_valid), .frm_len(frm_len), .frm_err(frm_err),
    .host_ret(host_ret), .host_ret_idx(host_ret_idx), .host_ret_wrap(host_ret_wrap),
    .host_rd_idx(host_rd_idx),
    .fill_we(fill_we), .fill_idx(fill_idx), .rd_flags(rd_flags),
    .frame_done(frame_done), .done_idx(done_idx), .cur_idx(cur_idx),
    .rx_active(rx_active), .overrun(overrun)
  );

  // lengths: host return zeroes (port a), engine fill overrides (port b)
  rxdesc_ram #(.WIDTH(LEN_W), .DEPTH(NUM_DESC)) u_len_ram (
    .clk(clk),
    .we_a(host_ret), .addr_a(host_ret_idx), .din_a('0),
    .we_b(fill_we), .addr_b(fill_idx), .din_b(frm_len),
    .raddr(host_rd_idx), .dout(rd_len)
  );

  rxdesc_ram #(.WIDTH(PTR_W), .DEPTH(NUM_DESC)) u_ptr_ram (
    .clk(clk),
    .we_a(host_ptr_we), .addr_a(host_ptr_idx), .din_a(host_ptr_data),
    .we_b(1'b0), .addr_b('0), .din_b('0),
    .raddr(host_rd_idx), .dout(rd_ptr)
  );

  assign rd_status = rd_flags;

endmodule

// File: rtl/rxdesc_ring_chk.sv
module rxdesc_ring_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             frm_valid,
  input logic             host_ret,
  input logic             frame_done,
  input logic [IDX_W-1:0] done_idx,
  input logic [IDX_W-1:0] cur_idx,
  input logic             rx_active,
  input logic             overrun
);

  assert_done_follows_frame_R3: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> ($past(frm_valid) && done_idx == $past(cur_idx)));

  assert_index_moves_only_on_fill_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_idx) |-> frame_done);

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_stop_needs_dropped_frame_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_active) |-> ($past(frm_valid) && overrun));

  assert_no_fill_when_stopped_R7: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(rx_active));

  assert_restart_by_return_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_active) |-> $past(host_ret));

endmodule

bind rxdesc_ring rxdesc_ring_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .frm_valid(frm_valid), .host_ret(host_ret),
  .frame_done(frame_done), .done_idx(done_idx), .cur_idx(cur_idx),
  .rx_active(rx_active), .overrun(overrun)
);

// File: tb/rxdesc_ring_test.sv
module rxdesc_ring_test;
  localparam int N     = 8;
  localparam int IDX_W = 3;
  localparam int LEN_W = 16;
  localparam int PTR_W = 32;

  logic clk = 1'b0;
  logic rst;
  logic frm_valid = 0, frm_err = 0, host_ret = 0, host_ret_wrap = 0, host_ptr_we = 0;
  logic [LEN_W-1:0] frm_len = '0;
  logic [IDX_W-1:0] host_ret_idx = '0, host_ptr_idx = '0, host_rd_idx = '0;
  logic [PTR_W-1:0] host_ptr_data = '0;
  logic [3:0]       rd_status;
  logic [LEN_W-1:0] rd_len;
  logic [PTR_W-1:0] rd_ptr;
  logic             frame_done, rx_active, overrun;
  logic [IDX_W-1:0] done_idx, cur_idx;

  always #5 clk = ~clk;

  rxdesc_ring uut (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_len(frm_len), .frm_err(frm_err),
    .host_ret(host_ret), .host_ret_idx(host_ret_idx), .host_ret_wrap(host_ret_wrap),
    .host_ptr_we(host_ptr_we), .host_ptr_idx(host_ptr_idx), .host_ptr_data(host_ptr_data),
    .host_rd_idx(host_rd_idx), .rd_status(rd_status), .rd_len(rd_len), .rd_ptr(rd_ptr),
    .frame_done(frame_done), .done_idx(done_idx), .cur_idx(cur_idx),
    .rx_active(rx_active), .overrun(overrun)
  );

  int checks = 0, errors = 0;
  bit m_empty[N], m_wrap[N], m_last[N], m_err[N], m_len_ok[N], m_ptr_ok[N];
  int m_len[N];
  logic [PTR_W-1:0] m_ptr[N];
  int m_cur, m_done_idx;
  bit m_act, m_ovr, m_done;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_bad(int len, bit e);
    return e || len > 1518 || len <= 14;
  endfunction

  function automatic int status_of(int i);
    return {28'd0, m_err[i], m_last[i], m_wrap[i], m_empty[i]};
  endfunction

  task automatic check_outs(string req);
    chk(req, "frame_done", frame_done, m_done);
    if (m_done) chk(req, "done_idx", done_idx, m_done_idx);
    chk(req, "cur_idx", cur_idx, m_cur);
    chk(req, "rx_active", rx_active, m_act);
    chk(req, "overrun", overrun, m_ovr);
  endtask

  // one operation cycle; the model uses the state from before the edge
  task automatic step(string req, bit v, int len, bit e, bit r, int ri, bit rw);
    bit acc, pre_wrap;
    int c;
    @(negedge clk);
    frm_valid = v; frm_len = LEN_W'(len); frm_err = e;
    host_ret = r; host_ret_idx = IDX_W'(ri); host_ret_wrap = rw;
    @(posedge clk);
    c = m_cur;
    acc = v && m_act && m_empty[c];
    pre_wrap = m_wrap[c];
    m_done = acc;
    if (v && !acc) begin m_ovr = 1; m_act = 0; end
    if (r) begin
      m_act = 1; m_empty[ri] = 1; m_wrap[ri] = rw || ri == N - 1;
      m_last[ri] = 0; m_err[ri] = 0; m_len[ri] = 0; m_len_ok[ri] = 1;
    end
    if (acc) begin
      m_empty[c] = 0; m_last[c] = 1; m_err[c] = is_bad(len, e); m_wrap[c] = pre_wrap;
      m_len[c] = len; m_len_ok[c] = 1; m_done_idx = c;
      m_cur = (pre_wrap || c == N - 1) ? 0 : c + 1;
    end
    @(negedge clk);
    check_outs(req);
    frm_valid = 0; host_ret = 0; host_ret_wrap = 0;
    m_done = 0;
  endtask

  task automatic read_desc(string req, int i);
    @(negedge clk);
    host_rd_idx = IDX_W'(i);
    @(negedge clk);
    chk(req, $sformatf("status[%0d]", i), rd_status, status_of(i));
    if (m_len_ok[i]) chk(req, $sformatf("len[%0d]", i), rd_len, m_len[i]);
    if (m_ptr_ok[i]) chk("R2", $sformatf("ptr[%0d]", i), rd_ptr, m_ptr[i]);
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < N; i++) read_desc(req, i);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_empty[i] = 1; m_wrap[i] = (i == N - 1); m_last[i] = 0; m_err[i] = 0;
      m_len[i] = 0; m_len_ok[i] = 0; m_ptr_ok[i] = 0; m_ptr[i] = '0;
    end
    m_cur = 0; m_act = 1; m_ovr = 0; m_done = 0; m_done_idx = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    check_outs("R1");
    read_all("R1");

    // R2: buffer addresses
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      host_ptr_we = 1; host_ptr_idx = IDX_W'(i); host_ptr_data = 32'h1000_0000 + 32'(i * 32'h600);
      m_ptr[i] = host_ptr_data; m_ptr_ok[i] = 1;
    end
    @(negedge clk) host_ptr_we = 0;
    read_all("R2");

    // R3 R5: fills with length boundaries
    step("R3", 1, 64, 0, 0, 0, 0);
    step("R5", 1, 14, 0, 0, 0, 0);
    step("R5", 1, 15, 0, 0, 0, 0);
    step("R5", 1, 1518, 0, 0, 0, 0);
    step("R5", 1, 1519, 0, 0, 0, 0);
    step("R5", 1, 100, 1, 0, 0, 0);
    step("R3", 1, 200, 0, 0, 0, 0);
    step("R4", 1, 300, 0, 0, 0, 0);   // fills index 7, wraps to 0
    read_all("R3");
    // R6: current descriptor owned by host
    step("R6", 1, 80, 0, 0, 0, 0);
    read_desc("R6", 0);
    // R7: stopped engine drops
    step("R7", 1, 90, 0, 0, 0, 0);
    read_desc("R7", 0);
    // R9 R10: return the blocking entry while another frame arrives
    step("R9", 1, 70, 0, 1, 0, 0);
    read_desc("R10", 0);
    // R9: return alone restarts; frame then fills it
    step("R9", 0, 0, 0, 1, 1, 0);
    step("R3", 1, 77, 0, 1, 0, 0);     // fill 0 and return 1 together (R10)
    read_desc("R8", 0);
    read_desc("R8", 1);
    // R8 R4: shorten the ring at index 2
    step("R8", 0, 0, 0, 1, 2, 1);
    step("R4", 1, 50, 0, 0, 0, 0);     // fills 1
    step("R4", 1, 51, 0, 0, 0, 0);     // fills 2, wrap flag returns to 0
    read_all("R8");
    // R10: fill and return of the same index in one cycle
    step("R10", 0, 0, 0, 1, 0, 0);
    step("R10", 1, 55, 0, 1, 0, 0);
    read_desc("R10", 0);

    // random mix
    for (int k = 0; k < 600; k++) begin
      bit v, r, rw, e;
      int len, ri;
      v   = ($urandom_range(0, 99) < 55);
      r   = ($urandom_range(0, 99) < 50);
      rw  = ($urandom_range(0, 99) < 8);
      e   = ($urandom_range(0, 99) < 10);
      len = $urandom_range(0, 1600);
      ri  = (r && $urandom_range(0, 1)) ? m_cur : $urandom_range(0, N - 1);
      step("R10", v, len, e, r, ri, rw);
      if (k % 60 == 59) read_all("R10");
    end
    read_all("R10");
    finish_run();
  end
endmodule